// File: doc/BRIEF.md
# Receive Ring Buffer Write Address Generator

This block produces byte offsets into a circular host memory buffer that holds received frames. A frame is opened with a start strobe. Each accepted write then moves the write offset forward by the byte count of that write. A frame-end strobe closes the frame and fixes the offset at which the following frame will begin. The ring has one of four nominal sizes, 8, 16, 32 or 64 KiB. The memory behind each size carries 16 extra bytes of padding.

A wrap-mode bit selects what happens when a frame runs past the nominal end of the ring:

- **Folding mode:** writing continues from the ring start.
- **Linear mode:** the frame keeps writing past the end into spare memory. The next frame then begins at an offset equal to the number of bytes that spilled. Software reserves 1.5 KiB beyond the end for this. A spill larger than 1536 bytes raises an error flag.
- **64 KiB ring:** linear mode is ignored and data always folds.

The ring size and mode are captured when a frame opens, so a change made mid-frame takes effect only on the next frame.

Top module: `rx_ring_addr_gen`

## Requirements
- R1: While rst_ni is low, and after it rises until the first frame start, wr_offset_o and next_start_o are 0 and spill_err_o is 0.
- R2: On a cycle with frame_start_i high, wr_offset_o takes next_start_o on the following cycle. If next_start_o is not below the ring size selected by len_code_i in that cycle, it takes 0 instead. Frame start has priority over a frame end in the same cycle.
- R3: While a frame is open, each cycle with wr_valid_i high adds wr_bytes_i to wr_offset_o on the next cycle. A write on a frame-start cycle and a write while no frame is open leave wr_offset_o unchanged.
- R4: len_code_i selects the nominal ring size: 0 is 8192, 1 is 16384, 2 is 32768 and 3 is 65536 bytes. In folding mode (wrap_mode_i = 0), a sum reaching that size becomes sum minus size.
- R5: In linear mode (wrap_mode_i = 1) with codes 0 to 2, the offset grows past the nominal size without folding.
- R6: At frame end, the final offset includes any write in that same cycle, and wr_offset_o holds that final offset F. next_start_o becomes F minus size if F is at least the size, and F otherwise.
- R7: With code 3, wrap_mode_i has no effect and offsets fold at 65536.
- R8: At frame end in linear mode, spill_err_o goes to 1 when F minus size exceeds 1536; a spill of exactly 1536 leaves it 0. It returns to 0 the cycle after the next frame start.
- R9: Changes on len_code_i and wrap_mode_i while a frame is open do not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| len_code_i | input | 2 | Ring size code, captured at frame start |
| wrap_mode_i | input | 1 | 1 selects linear overflow, captured at frame start |
| frame_start_i | input | 1 | Opens a frame |
| wr_valid_i | input | 1 | A write of wr_bytes_i bytes occurs this cycle |
| wr_bytes_i | input | 11 | Byte count of the current write |
| frame_end_i | input | 1 | Closes the frame after any same-cycle write |
| wr_offset_o | output | 17 | Offset of the next byte to be written |
| next_start_o | output | 17 | Offset at which the next frame begins |
| spill_err_o | output | 1 | Spill exceeded the reserved space at the last frame end |

## Verification
A corrupted cursor shows on wr_offset_o one cycle after the write that produced it. A bad fold decision appears as an offset at or above the ring size, or as a premature drop toward zero. A wrong captured configuration shows only when a frame crosses the ring end, so the stimulus drives frames across every fold point, including the 64 KiB ring. An error in the spill arithmetic surfaces on next_start_o and spill_err_o one cycle after frame end. It also surfaces once more through the start-offset clamp when the next frame opens.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef enum logic [1:0] {
    RING_8K  = 2'd0,
    RING_16K = 2'd1,
    RING_32K = 2'd2,
    RING_64K = 2'd3
  } ring_len_e;

  localparam int unsigned RING_LOG2_MIN = 13;
  localparam int unsigned RING_CODES    = 4;
endpackage

// File: rtl/rxr_cfg.sv
module rxr_cfg
  import rxr_pkg::*;
#(
  parameter int unsigned AW = 17
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    len_code_i,
  input  logic          wrap_mode_i,
  output logic [AW-1:0] size_o,
  output logic [AW-1:0] start_size_o,
  output logic          linear_o
);
  logic [AW-1:0] size_tbl [RING_CODES];
  ring_len_e     len_q;
  logic          wrap_q;

  for (genvar g = 0; g < RING_CODES; g++) begin : g_size
    assign size_tbl[g] = AW'(1) << (RING_LOG2_MIN + g);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q  <= RING_8K;
      wrap_q <= 1'b0;
    end else if (start_i) begin
      len_q  <= ring_len_e'(len_code_i);
      wrap_q <= wrap_mode_i;
    end
  end

  assign size_o       = size_tbl[len_q];
  assign start_size_o = size_tbl[len_code_i];
  // largest ring always folds
  assign linear_o     = wrap_q && (len_q != RING_64K);
endmodule

// File: rtl/rxr_step.sv
module rxr_step #(
  parameter int unsigned AW        = 17,
  parameter int unsigned BW        = 11,
  parameter int unsigned SPILL_MAX = 1536
) (
  input  logic [AW-1:0] cur_i,
  input  logic [BW-1:0] bytes_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] size_i,
  input  logic          linear_i,
  output logic [AW-1:0] adv_o,
  output logic [AW-1:0] next_o,
  output logic          err_o
);
  logic [AW-1:0] sum, over_amt;
  logic          over;

  always_comb begin
    sum      = cur_i + (wr_en_i ? AW'(bytes_i) : '0);
    over     = sum >= size_i;
    over_amt = sum - size_i;
    // one subtractor serves both the fold and the spill
    next_o   = over ? over_amt : sum;
    adv_o    = linear_i ? sum : next_o;
    err_o    = linear_i && over && (over_amt > AW'(SPILL_MAX));
  end
endmodule

// File: rtl/rxr_cursor.sv
module rxr_cursor #(
  parameter int unsigned AW = 17
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          end_i,
  input  logic [AW-1:0] start_size_i,
  input  logic [AW-1:0] adv_i,
  input  logic [AW-1:0] next_i,
  input  logic          err_i,
  output logic [AW-1:0] off_o,
  output logic [AW-1:0] next_o,
  output logic          err_o,
  output logic          active_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_o    <= '0;
      next_o   <= '0;
      err_o    <= 1'b0;
      active_o <= 1'b0;
    end else if (start_i) begin
      active_o <= 1'b1;
      err_o    <= 1'b0;
      off_o    <= (next_o >= start_size_i) ? '0 : next_o;
    end else if (active_o) begin
      off_o <= adv_i;
      if (end_i) begin
        active_o <= 1'b0;
        next_o   <= next_i;
        err_o    <= err_i;
      end
    end
  end

  // R3
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_o && !start_i) |=> $stable(off_o));

  // R8
  err_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !err_o);

  // R6
  next_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(active_o && end_i) |=> $stable(next_o));
endmodule

// File: rtl/rx_ring_addr_gen.sv
module rx_ring_addr_gen #(
  parameter int unsigned AW        = 17,
  parameter int unsigned BW        = 11,
  parameter int unsigned SPILL_MAX = 1536
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    len_code_i,
  input  logic          wrap_mode_i,
  input  logic          frame_start_i,
  input  logic          wr_valid_i,
  input  logic [BW-1:0] wr_bytes_i,
  input  logic          frame_end_i,
  output logic [AW-1:0] wr_offset_o,
  output logic [AW-1:0] next_start_o,
  output logic          spill_err_o
);
  logic [AW-1:0] size_q, start_size, adv, next_d;
  logic          linear_q, active, err_d, wr_en;

  assign wr_en = wr_valid_i && active && !frame_start_i;

  rxr_cfg #(.AW(AW)) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (frame_start_i),
    .len_code_i  (len_code_i),
    .wrap_mode_i (wrap_mode_i),
    .size_o      (size_q),
    .start_size_o(start_size),
    .linear_o    (linear_q)
  );

  rxr_step #(.AW(AW), .BW(BW), .SPILL_MAX(SPILL_MAX)) u_step (
    .cur_i   (wr_offset_o),
    .bytes_i (wr_bytes_i),
    .wr_en_i (wr_en),
    .size_i  (size_q),
    .linear_i(linear_q),
    .adv_o   (adv),
    .next_o  (next_d),
    .err_o   (err_d)
  );

  rxr_cursor #(.AW(AW)) u_cursor (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (frame_start_i),
    .end_i       (frame_end_i),
    .start_size_i(start_size),
    .adv_i       (adv),
    .next_i      (next_d),
    .err_i       (err_d),
    .off_o       (wr_offset_o),
    .next_o      (next_start_o),
    .err_o       (spill_err_o),
    .active_o    (active)
  );

  // R4
  wrap_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && !linear_q) |-> (wr_offset_o < size_q));

  // R6
  next_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && frame_end_i && !frame_start_i) |=> (next_start_o < size_q));

  // R5
  linear_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && linear_q && wr_valid_i && !frame_start_i && !frame_end_i)
    |=> (wr_offset_o == $past(wr_offset_o) + AW'($past(wr_bytes_i))));

  // R2
  start_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> (wr_offset_o < size_q));
endmodule

// File: tb/tb_rx_ring_addr_gen.sv
module tb_rx_ring_addr_gen;
  localparam int unsigned AW = 17;
  localparam int unsigned BW = 11;

  typedef struct packed {
    logic          s;
    logic          w;
    logic          e;
    logic [1:0]    len;
    logic          wrap;
    logic [BW-1:0] bytes;
    logic [AW-1:0] off;
    logic [AW-1:0] nxt;
    logic          err;
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t TBL [NV] = '{
    '{1'b1,1'b0,1'b0,2'd0,1'b0,11'd0,   17'd0,   17'd0,   1'b0,4'd2}, // R2
    '{1'b0,1'b1,1'b0,2'd0,1'b0,11'd1000,17'd1000,17'd0,   1'b0,4'd3}, // R3
    '{1'b0,1'b1,1'b0,2'd0,1'b0,11'd1500,17'd2500,17'd0,   1'b0,4'd3}, // R3
    '{1'b0,1'b1,1'b0,2'd0,1'b0,11'd2000,17'd4500,17'd0,   1'b0,4'd3}, // R3
    '{1'b0,1'b1,1'b0,2'd0,1'b0,11'd2047,17'd6547,17'd0,   1'b0,4'd3}, // R3
    '{1'b0,1'b1,1'b0,2'd0,1'b0,11'd1953,17'd308, 17'd0,   1'b0,4'd4}, // R4 8500-8192
    '{1'b0,1'b0,1'b1,2'd0,1'b0,11'd0,   17'd308, 17'd308, 1'b0,4'd6}, // R6
    '{1'b0,1'b1,1'b0,2'd0,1'b0,11'd100, 17'd308, 17'd308, 1'b0,4'd3}, // R3 idle write
    '{1'b1,1'b1,1'b0,2'd0,1'b1,11'd100, 17'd308, 17'd308, 1'b0,4'd3}, // R3 start-cycle write
    '{1'b0,1'b1,1'b0,2'd0,1'b1,11'd2000,17'd2308,17'd308, 1'b0,4'd5}, // R5
    '{1'b0,1'b1,1'b0,2'd0,1'b1,11'd2000,17'd4308,17'd308, 1'b0,4'd5}, // R5
    '{1'b0,1'b1,1'b0,2'd0,1'b1,11'd2000,17'd6308,17'd308, 1'b0,4'd5}, // R5
    '{1'b0,1'b1,1'b0,2'd0,1'b1,11'd1800,17'd8108,17'd308, 1'b0,4'd5}, // R5
    '{1'b0,1'b1,1'b1,2'd0,1'b1,11'd600, 17'd8708,17'd516, 1'b0,4'd6}, // R6 spill 516
    '{1'b1,1'b0,1'b0,2'd2,1'b0,11'd0,   17'd516, 17'd516, 1'b0,4'd2}, // R2
    '{1'b0,1'b1,1'b0,2'd0,1'b1,11'd2047,17'd2563,17'd516, 1'b0,4'd9}, // R9 inputs changed
    '{1'b0,1'b1,1'b0,2'd0,1'b1,11'd2047,17'd4610,17'd516, 1'b0,4'd9}  // R9
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    len = '0;
  logic          wrap = 1'b0;
  logic          fs = 1'b0;
  logic          wv = 1'b0;
  logic [BW-1:0] wb = '0;
  logic          fe = 1'b0;
  logic [AW-1:0] off, nxt;
  logic          err;
  int            n_run = 0;
  int            n_fail = 0;
  logic [AW-1:0] exp_off;

  always #4 clk = ~clk;

  rx_ring_addr_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .len_code_i(len), .wrap_mode_i(wrap),
    .frame_start_i(fs), .wr_valid_i(wv), .wr_bytes_i(wb), .frame_end_i(fe),
    .wr_offset_o(off), .next_start_o(nxt), .spill_err_o(err)
  );

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input logic [AW-1:0] eo,
                         input logic [AW-1:0] en, input logic ee);
    chk({req, " offset"}, off, eo);
    chk({req, " next"}, nxt, en);
    chk({req, " err"}, AW'(err), AW'(ee));
  endtask

  // drive at negedge, one edge, sample at the following negedge
  task automatic step(input logic s, input logic w, input logic e,
                      input logic [1:0] l, input logic m, input logic [BW-1:0] b);
    fs = s; wv = w; fe = e; len = l; wrap = m; wb = b;
    @(posedge clk);
    @(negedge clk);
    fs = 1'b0; wv = 1'b0; fe = 1'b0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    chk_all("R1 in reset", 17'd0, 17'd0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk_all("R1 after reset", 17'd0, 17'd0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      step(TBL[i].s, TBL[i].w, TBL[i].e, TBL[i].len, TBL[i].wrap, TBL[i].bytes);
      chk_all($sformatf("R%0d row %0d", TBL[i].req, i), TBL[i].off, TBL[i].nxt, TBL[i].err);
    end

    // R9: frame captured as 32K folding; would fold at 8K if inputs were used
    step(1'b0, 1'b1, 1'b0, 2'd0, 1'b1, 11'd2047);
    step(1'b0, 1'b1, 1'b0, 2'd0, 1'b1, 11'd2047);
    chk_all("R9 past 8K", 17'd8704, 17'd516, 1'b0);
    step(1'b0, 1'b0, 1'b1, 2'd0, 1'b1, 11'd0);
    chk_all("R6 end 32K", 17'd8704, 17'd8704, 1'b0);

    // R2: start offset beyond new ring size clamps to 0
    step(1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 11'd0);
    chk_all("R2 clamp", 17'd0, 17'd8704, 1'b0);
    step(1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 11'd0);
    chk_all("R6 empty frame", 17'd0, 17'd0, 1'b0);

    // R8: 16K linear, spill 18000-16384 = 1616 > 1536
    step(1'b1, 1'b0, 1'b0, 2'd1, 1'b1, 11'd0);
    for (int k = 1; k <= 9; k++) begin
      step(1'b0, 1'b1, 1'b0, 2'd1, 1'b1, 11'd2000);
      chk("R5 16K linear", off, AW'(k * 2000));
    end
    step(1'b0, 1'b0, 1'b1, 2'd1, 1'b1, 11'd0);
    chk_all("R8 spill over", 17'd18000, 17'd1616, 1'b1);
    step(1'b1, 1'b0, 1'b0, 2'd1, 1'b1, 11'd0);
    chk_all("R8 err cleared", 17'd1616, 17'd1616, 1'b0);
    // spill of exactly 1536: 1616 + 16000 + 304 = 17920
    for (int k = 0; k < 8; k++) step(1'b0, 1'b1, 1'b0, 2'd1, 1'b1, 11'd2000);
    step(1'b0, 1'b1, 1'b1, 2'd1, 1'b1, 11'd304);
    chk_all("R8 spill at limit", 17'd17920, 17'd1536, 1'b0);

    // R7: 64K ignores linear mode
    step(1'b1, 1'b0, 1'b0, 2'd3, 1'b1, 11'd0);
    exp_off = 17'd1536;
    chk("R7 start", off, exp_off);
    for (int k = 0; k < 33; k++) begin
      step(1'b0, 1'b1, 1'b0, 2'd3, 1'b1, 11'd2000);
      exp_off = AW'((int'(exp_off) + 2000) % 65536);
      chk("R7 fold at 64K", off, exp_off);
    end
    step(1'b0, 1'b0, 1'b1, 2'd3, 1'b1, 11'd0);
    chk_all("R7 end", exp_off, exp_off, 1'b0);

    // R1: reset in mid-run
    step(1'b1, 1'b0, 1'b0, 2'd1, 1'b1, 11'd0);
    rst_n = 1'b0;
    @(negedge clk);
    chk_all("R1 mid-run reset", 17'd0, 17'd0, 1'b0);
    rst_n = 1'b1;
    step(1'b0, 1'b1, 1'b0, 2'd1, 1'b1, 11'd500);
    chk("R3 idle after reset", off, 17'd0);

    finish_run();
  end
endmodule